// File: doc/BRIEF.md
# Programmable Down-Count Watchdog Timer

This block is a general-purpose down counter of two equal halves, presented to software as a low word and a high word that together form one count. A periodic tick-enable input, which stands for a 5 MHz time base, advances the count by one step while the timer is running. When the count is already zero and a tick arrives, the counter reloads all ones, pulses a timer-complete event for one cycle, and keeps counting. The event is meant to feed bit 7 of the interrupt status register.

Two command bits control the timer: one starts it and one stops it. A command register write carries them, and each command clears the other's latched bit. Software can rewrite either half at any time, and counting continues from the new value. A soft-reset input halts the timer. The interrupt mask and the rest of the command register live outside this block.

Top module: `wdog_downcounter`

## Requirements
- R1: After hardware reset the count is 0, the stop bit reads 1, the start bit reads 0 and the timer-complete pulse is low.
- R2: The count is {cnt_hi, cnt_lo}. The outputs show the live register value one cycle after each change, and a decrement borrows from the high half into the low half (0x0001_0000 becomes 0x0000_FFFF).
- R3: While the stop bit is 0 and no count write is present, each cycle with tick=1 lowers a non-zero count by exactly one. Cycles with tick=0 leave the count unchanged.
- R4: A command write with cmd_start=1 sets the start bit and clears the stop bit. Counting then resumes from the count already held.
- R5: A command write with cmd_stop=1 and cmd_start=0 sets the stop bit and clears the start bit. The count stays frozen at its present value afterwards.
- R6: A tick that arrives while the timer runs and the count is 0 loads all ones into both halves and raises tc_pulse for exactly one cycle. The timer stays running, so the next tick gives 0xFFFF_FFFE.
- R7: While the stop bit is 1, ticks change neither the count nor tc_pulse, even when the count is 0.
- R8: wr_lo and wr_hi load wr_data into the low or high half. The other half is unchanged. A tick in the same cycle is dropped, and later ticks count down from the written value. Writes are accepted whether the timer is running or stopped.
- R9: soft_rst=1 sets the stop bit and clears the start bit. It overrides a start command in the same cycle.
- R10: A command write with both cmd_start=1 and cmd_stop=1 leaves the timer running: the start bit is 1 and the stop bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| tick | input | 1 | Count enable, one cycle per 5 MHz period |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_start | input | 1 | Start bit of the command write |
| cmd_stop | input | 1 | Stop bit of the command write |
| soft_rst | input | 1 | Soft-reset command, halts the timer |
| wr_lo | input | 1 | Write strobe for the low half of the count |
| wr_hi | input | 1 | Write strobe for the high half of the count |
| wr_data | input | HALF_W | Data for a count half write |
| cnt_lo | output | HALF_W | Live low half of the count |
| cnt_hi | output | HALF_W | Live high half of the count |
| start_bit | output | 1 | Latched start command bit |
| stop_bit | output | 1 | Latched stop command bit |
| tc_pulse | output | 1 | One-cycle timer-complete event |

## Verification
The hardest case to reach is the underflow: at the reset width, counting down from a large value would take billions of ticks. The stimulus instead writes a small value into the low half and zero into the high half while the timer is stopped. It then starts the timer and ticks through 2, 1, 0 to the reload. The same shortcut covers the other edge cases. Writing 0x0001 into the high half with 0 in the low half checks the borrow across halves. Writing 0 while stopped and then ticking checks that a stopped counter at zero never fires.

// File: rtl/wdog_downcounter.sv
module wdog_downcounter #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_wr,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              soft_rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              start_bit,
  output logic              stop_bit,
  output logic              tc_pulse
);
  localparam int CW = 2 * HALF_W;

  logic [CW-1:0] cnt_q;
  logic          stop_q, start_q, tc_q;

  wire wr_any = wr_lo | wr_hi;
  wire adv    = tick & ~stop_q & ~wr_any;
  wire zero   = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= adv & zero;
      if (wr_any) begin
        if (wr_lo) cnt_q[HALF_W-1:0]  <= wr_data;
        if (wr_hi) cnt_q[CW-1:HALF_W] <= wr_data;
      end else if (adv) begin
        cnt_q <= zero ? '1 : cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b1;
      start_q <= 1'b0;
    end else if (soft_rst) begin
      stop_q  <= 1'b1;
      start_q <= 1'b0;
    end else if (cmd_wr && cmd_start) begin
      stop_q  <= 1'b0;
      start_q <= 1'b1;
    end else if (cmd_wr && cmd_stop) begin
      stop_q  <= 1'b1;
      start_q <= 1'b0;
    end
  end

  assign cnt_lo    = cnt_q[HALF_W-1:0];
  assign cnt_hi    = cnt_q[CW-1:HALF_W];
  assign start_bit = start_q;
  assign stop_bit  = stop_q;
  assign tc_pulse  = tc_q;

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop_q && !wr_lo && !wr_hi && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop_q && !wr_lo && !wr_hi && cnt_q == '0) |=> (cnt_q == '1 && tc_pulse));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_lo && !wr_hi) |=> ($stable(cnt_q) && !tc_pulse));

  assert_wr_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(wr_data)));

  assert_wr_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_hi == $past(wr_data)));

  assert_soft_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stop_bit && !start_bit));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_bit && start_bit));
endmodule

// File: tb/wdog_downcounter_tb.sv
`timescale 1ns/1ps
module wdog_downcounter_tb;
  localparam int HW = 16;
  localparam int CW = 2 * HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, cmd_wr = 0, cmd_start = 0, cmd_stop = 0, soft_rst = 0;
  logic wr_lo = 0, wr_hi = 0;
  logic [HW-1:0] wr_data = '0;
  logic [HW-1:0] cnt_lo, cnt_hi;
  logic start_bit, stop_bit, tc_pulse;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [CW-1:0] exp_cnt[$];
  logic [2:0]    exp_flg[$];
  string         exp_tag[$];

  logic [CW-1:0] m_cnt;
  logic m_stop, m_start;

  always #5 clk = ~clk;

  wdog_downcounter #(.HALF_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_wr(cmd_wr),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .soft_rst(soft_rst),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .start_bit(start_bit),
    .stop_bit(stop_bit), .tc_pulse(tc_pulse)
  );

  task automatic cmp(string tag, logic [CW-1:0] ec, logic [2:0] ef);
    checks++;
    if ({cnt_hi, cnt_lo} !== ec || {stop_bit, start_bit, tc_pulse} !== ef) begin
      failures++;
      $display("FAIL %s: cnt=%h stop/start/tc=%b expected cnt=%h stop/start/tc=%b",
               tag, {cnt_hi, cnt_lo}, {stop_bit, start_bit, tc_pulse}, ec, ef);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_cnt.size() > 0)
        cmp(exp_tag.pop_front(), exp_cnt.pop_front(), exp_flg.pop_front());
    end
  end

  task automatic cyc(bit t, bit cw, bit cs, bit cp, bit sr, bit wl, bit wh,
                     logic [HW-1:0] d, string tag);
    bit adv, ntc;
    @(negedge clk);
    tick = t; cmd_wr = cw; cmd_start = cs; cmd_stop = cp; soft_rst = sr;
    wr_lo = wl; wr_hi = wh; wr_data = d;
    adv = t && !m_stop && !(wl || wh);
    ntc = adv && (m_cnt == '0);
    if (wl || wh) begin
      if (wl) m_cnt[HW-1:0]  = d;
      if (wh) m_cnt[CW-1:HW] = d;
    end else if (adv) begin
      m_cnt = (m_cnt == '0) ? '1 : m_cnt - 1;
    end
    if (sr) begin m_stop = 1; m_start = 0; end
    else if (cw && cs) begin m_stop = 0; m_start = 1; end
    else if (cw && cp) begin m_stop = 1; m_start = 0; end
    exp_cnt.push_back(m_cnt);
    exp_flg.push_back({m_stop, m_start, ntc});
    exp_tag.push_back(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_cnt = '0; m_stop = 1; m_start = 0;
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 reset state", '0, 3'b100);
    @(negedge clk);
    rst_n = 1;

    cyc(1,0,0,0,0,0,0,'0,"R7 tick while stopped at zero");
    cyc(0,0,0,0,0,1,0,16'd5,"R8 write low half while stopped");
    cyc(0,0,0,0,0,0,1,16'd0,"R8 write high half keeps low");
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,0,0,0,'0,"R7 ticks while stopped");
    cyc(0,1,1,0,0,0,0,'0,"R4 start command");
    for (int i = 0; i < 2; i++) cyc(1,0,0,0,0,0,0,'0,"R3 tick decrements");
    for (int i = 0; i < 3; i++) cyc(0,0,0,0,0,0,0,'0,"R3 no tick holds");
    cyc(1,0,0,0,0,0,1,16'd1,"R8 write high with tick dropped");
    cyc(1,0,0,0,0,1,0,16'd0,"R8 write low with tick dropped");
    cyc(1,0,0,0,0,0,0,'0,"R2 borrow across halves");
    cyc(1,0,0,0,0,0,0,'0,"R2 live count after borrow");
    cyc(0,0,0,0,0,1,1,16'd0,"R8 write both halves");
    cyc(1,0,0,0,0,1,0,16'd2,"R8 write low running tick dropped");
    cyc(1,0,0,0,0,0,0,'0,"R3 count to 1");
    cyc(1,0,0,0,0,0,0,'0,"R3 count to 0");
    cyc(1,0,0,0,0,0,0,'0,"R6 underflow reload and pulse");
    cyc(1,0,0,0,0,0,0,'0,"R6 keeps running after reload");
    cyc(0,0,0,0,0,0,0,'0,"R6 pulse lasts one cycle");
    cyc(0,1,0,1,0,0,0,'0,"R5 stop command");
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,0,0,0,'0,"R5 count frozen after stop");
    cyc(0,0,0,0,0,1,1,16'd0,"R8 write zero while stopped");
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,0,0,0,'0,"R7 no underflow while stopped");
    cyc(0,1,1,1,0,0,0,'0,"R10 start and stop together");
    cyc(1,0,0,0,0,0,0,'0,"R6 underflow after R10 start");
    cyc(1,0,0,0,0,0,0,'0,"R3 running after underflow");
    cyc(1,1,1,0,1,0,0,'0,"R9 soft reset beats start");
    for (int i = 0; i < 2; i++) cyc(1,0,0,0,0,0,0,'0,"R9 halted after soft reset");
    cyc(0,1,1,0,0,0,0,'0,"R4 restart after soft reset");
    cyc(1,0,0,0,0,0,0,'0,"R4 resumes from held count");
    cyc(0,0,0,0,0,0,0,'0,"R3 idle");
    @(posedge clk);
    #2;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule